// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Arbiter

This block arbitrates seven interrupt sources for a small 8-bit controller core. The sources are two external lines, three timer overflows, a serial port and a counter-array unit. Software writes three 8-bit registers: an enable register with a global gate in bit 7, and two priority registers. For each source, one priority register supplies the upper bit of its level and the other supplies the lower bit, which gives four nesting levels.

Every cycle the block finds the highest-level source that is pending and enabled. Sources on the same level are resolved by a fixed polling order. The winner is registered and presented to the core as a request plus a vector index. A 4-bit in-service mask holds one bit per level. An acknowledge sets the bit for the level being served, and a return pulse clears the highest set bit. A new request is raised only when its level is strictly above every level now in service, which gives properly nested interrupts. The pending inputs are flags held by the peripherals, and this block never clears them.

Top module: `nested_irq_arbiter`

## Requirements
- R1: After reset the enable register, both priority registers and the in-service mask are zero, and irq_o and vec_o are both 0.
- R2: Enable bits 0..6 gate, in order, external 0, timer 0, external 1, timer 1, serial port, timer 2 and counter array. A pending source whose own enable bit is 0 is never requested.
- R3: While enable bit 7 (the global gate) is 0, irq_o stays 0 whatever the other bits and the pending inputs are.
- R4: The level of source i is {hi[i], lo[i]}, where 3 is the highest and 0 the lowest. Bit 7 of both priority registers is ignored. Among eligible sources, one at the highest level wins.
- R5: A request is raised only when the winner's level is strictly greater than the highest level set in the in-service mask. A request at the same level or a lower one waits.
- R6: While level 3 is in service, irq_o stays 0.
- R7: Ties within a level go to the source with the lowest bit index. vec_o equals that bit index (0..6).
- R8: An acknowledge sampled with irq_o high sets the in-service bit of the presented level. irq_o is 0 in the cycle after any acknowledge or return pulse.
- R9: A return pulse clears the highest set in-service bit. Lower-level requests that were blocked may then be raised.
- R10: A register write takes effect in arbitration on the next cycle, so irq_o reflects it after the second clock edge that follows the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_we | input | 1 | Write strobe, enable register |
| hi_we | input | 1 | Write strobe, upper priority-bit register |
| lo_we | input | 1 | Write strobe, lower priority-bit register |
| wdata | input | 8 | Register write data |
| pend_i | input | NSRC | Pending flags, one per source |
| ack_i | input | 1 | Core acknowledge of the presented request |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | IDX_W | Vector index of the presented source |

## Verification
The bench builds the block with its defaults, NSRC = 7 and LVL_W = 2. These values make all four nesting levels and the full seven-entry polling order reachable, including level 3 blocking everything. With them, the table covers the global and per-source gating, level comparison across the two priority registers, and same-level ties. Directed sequences then push the in-service mask through a nest of levels 0, 1 and 3 and unwind it with return pulses.

// File: rtl/nested_irq_arbiter.sv
module nested_irq_arbiter #(
  parameter int NSRC  = 7,
  parameter int LVL_W = 2,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             hi_we,
  input  logic             lo_we,
  input  logic [7:0]       wdata,
  input  logic [NSRC-1:0]  pend_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] vec_o
);
  localparam int NLVL = 1 << LVL_W;

  logic [7:0]       en_q;
  logic [NSRC-1:0]  hi_q, lo_q;
  logic [NLVL-1:0]  isr_q;
  logic             irq_q;
  logic [IDX_W-1:0] vec_q;
  logic [LVL_W-1:0] lvl_q;

  logic [NSRC-1:0]  elig;
  logic             found;
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;
  logic             busy;
  logic [LVL_W-1:0] top_lvl;
  logic [NLVL-1:0]  top_mask;
  logic             allow;

  assign elig = pend_i & en_q[NSRC-1:0] & {NSRC{en_q[7]}};

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || {hi_q[i], lo_q[i]} > best_lvl)) begin
        found    = 1'b1;
        best_lvl = {hi_q[i], lo_q[i]};
        best_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    busy     = 1'b0;
    top_lvl  = '0;
    top_mask = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isr_q[l]) begin
        busy     = 1'b1;
        top_lvl  = LVL_W'(l);
        top_mask = NLVL'(1) << l;
      end
    end
  end

  assign allow = !busy || (best_lvl > top_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      if (hi_we) hi_q <= wdata[NSRC-1:0];
      if (lo_we) lo_q <= wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
      isr_q <= '0;
    end else begin
      if (ack_i || reti_i) irq_q <= 1'b0;
      else                 irq_q <= found && allow;
      if (!(ack_i || reti_i) && found) begin
        vec_q <= best_idx;
        lvl_q <= best_lvl;
      end
      isr_q <= (isr_q & ~(reti_i ? top_mask : '0))
             | ((ack_i && irq_q) ? (NLVL'(1) << lvl_q) : '0);
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq_q || $past(rst_n)));

  assert_gate_global_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(en_q[7]));

  assert_winner_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(elig) & (NSRC'(1) << vec_q)) != '0);

  assert_strict_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (!$past(busy) || lvl_q > $past(top_lvl)));

  assert_top_level_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(isr_q[NLVL-1]) |-> !irq_q);

  assert_ack_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i || reti_i) |=> !irq_q);

  assert_ack_marks_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_q && !reti_i) |=> isr_q[$past(lvl_q)]);

  assert_reti_clears_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_i && busy) |=> !isr_q[$past(top_lvl)]);
endmodule

// File: tb/nested_irq_arbiter_bench.sv
module nested_irq_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_we = 1'b0, hi_we = 1'b0, lo_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [6:0] pend_i = '0;
  logic       ack_i = 1'b0, reti_i = 1'b0;
  logic       irq_o;
  logic [2:0] vec_o;

  int nchk = 0;
  int nbad = 0;

  always #2.5 clk = ~clk;

  nested_irq_arbiter u_nested_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .hi_we(hi_we), .lo_we(lo_we),
    .wdata(wdata), .pend_i(pend_i), .ack_i(ack_i), .reti_i(reti_i),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  // {en, hi, lo, pend(8b), exp_irq, exp_vec(3b)}
  localparam int NV = 10;
  localparam logic [35:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 8'h7F, 1'b0, 3'd0},  // R1 R3: all off
    {8'h7F, 8'h00, 8'h00, 8'h7F, 1'b0, 3'd0},  // R3: global gate low
    {8'hFF, 8'h00, 8'h00, 8'h7F, 1'b1, 3'd0},  // R7: poll first
    {8'hFF, 8'h00, 8'h00, 8'h60, 1'b1, 3'd5},  // R7: timer 2 before counter array
    {8'hFF, 8'h00, 8'h40, 8'h41, 1'b1, 3'd6},  // R4: level 1 beats level 0
    {8'hFF, 8'h10, 8'h08, 8'h18, 1'b1, 3'd4},  // R4: level 2 beats level 1
    {8'hFF, 8'h22, 8'h22, 8'h7F, 1'b1, 3'd1},  // R4 R7: two at level 3
    {8'hFE, 8'h00, 8'h00, 8'h01, 1'b0, 3'd0},  // R2: own enable off
    {8'h84, 8'h00, 8'h00, 8'h05, 1'b1, 3'd2},  // R2: only ext 1 enabled
    {8'hFF, 8'h80, 8'h80, 8'h03, 1'b1, 3'd0}   // R4: priority bit 7 ignored
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [7:0] d);
    wdata = d;
    en_we = (sel == 0);
    hi_we = (sel == 1);
    lo_we = (sel == 2);
    @(negedge clk);
    en_we = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic pulse_reti();
    reti_i = 1'b1;
    @(negedge clk);
    reti_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    #100000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", {3'b0, irq_o}, 4'd0);
    check("R1 vec", {1'b0, vec_o}, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    pend_i = 7'h7F;
    @(negedge clk);
    check("R1 enables zero", {3'b0, irq_o}, 4'd0);

    for (int k = 0; k < NV; k++) begin
      pend_i = '0;
      wr(0, VEC[k][35:28]);
      wr(1, VEC[k][27:20]);
      wr(2, VEC[k][19:12]);
      pend_i = VEC[k][10:4];
      @(negedge clk);
      @(negedge clk);
      check($sformatf("R2-table row %0d irq", k), {3'b0, irq_o}, {3'b0, VEC[k][3]});
      if (VEC[k][3])
        check($sformatf("R7 table row %0d vec", k), {1'b0, vec_o}, {1'b0, VEC[k][2:0]});
    end

    // R10: write timing
    pend_i = 7'h00;
    wr(0, 8'h00);
    wr(1, 8'h00);
    wr(2, 8'h00);
    pend_i = 7'h01;
    @(negedge clk);
    wr(0, 8'hFF);
    check("R10 one edge after write", {3'b0, irq_o}, 4'd0);
    @(negedge clk);
    check("R10 two edges after write", {3'b0, irq_o}, 4'd1);
    check("R10 vec", {1'b0, vec_o}, 4'd0);

    // Nesting: ext0 level 0, timer0 level 1, ext1 level 3
    wr(2, 8'h06);
    wr(1, 8'h04);
    @(negedge clk);
    check("R5 level0 idle mask", {3'b0, irq_o}, 4'd1);
    pulse_ack();
    check("R8 irq low after ack", {3'b0, irq_o}, 4'd0);
    @(negedge clk);
    check("R5 same level waits", {3'b0, irq_o}, 4'd0);
    pend_i = 7'h03;
    @(negedge clk);
    check("R5 higher level preempts", {3'b0, irq_o}, 4'd1);
    check("R5 vec timer0", {1'b0, vec_o}, 4'd1);
    pulse_ack();
    @(negedge clk);
    check("R8 level1 now in service", {3'b0, irq_o}, 4'd0);
    pend_i = 7'h07;
    @(negedge clk);
    check("R5 level3 preempts level1", {3'b0, irq_o}, 4'd1);
    check("R5 vec ext1", {1'b0, vec_o}, 4'd2);
    pulse_ack();
    @(negedge clk);
    @(negedge clk);
    check("R6 level3 blocks all", {3'b0, irq_o}, 4'd0);
    pend_i = 7'h03;
    pulse_reti();
    check("R8 irq low after reti", {3'b0, irq_o}, 4'd0);
    @(negedge clk);
    check("R9 level1 still in service", {3'b0, irq_o}, 4'd0);
    pulse_reti();
    @(negedge clk);
    check("R9 level1 resumes over level0", {3'b0, irq_o}, 4'd1);
    check("R9 vec timer0", {1'b0, vec_o}, 4'd1);
    pend_i = 7'h01;
    @(negedge clk);
    check("R9 level0 blocked by level0", {3'b0, irq_o}, 4'd0);
    pulse_reti();
    @(negedge clk);
    check("R9 mask empty, level0 served", {3'b0, irq_o}, 4'd1);
    check("R9 vec ext0", {1'b0, vec_o}, 4'd0);

    // R3: clearing the global gate drops the request
    wr(0, 8'h7F);
    @(negedge clk);
    check("R3 gate cleared", {3'b0, irq_o}, 4'd0);

    summary();
  end
endmodule